// File: doc/BRIEF.md
# Cartridge Interval IRQ Timer

This block sits beside a serially loaded cartridge bank mapper and adds a long-period interrupt timer and a PRG bank override. The mapper's loader delivers the 5-bit value destined for its first CHR bank register to this block through a write strobe, and the block uses that value as a control word. Bit 4 of the stored word halts the timer and holds its counter at zero. While bit 4 is clear, the counter advances once per CPU cycle. Bit 3 picks the PRG layout. Bits 2:1 pick a 32 KB bank when bit 3 is clear.

When the counter reaches a threshold, it wraps to zero and raises a level-sensitive interrupt request. The threshold is 2^BASE_BIT plus the 4-bit switch setting times 2^SW_LSB; the defaults give 0x20000000 + switch × 2^25 cycles, and the switches normally sit at 4. The request stays high until a control write with bit 4 set, or reset, clears it.

The timer runs as a three-state machine:
- COUNT: running, request low.
- PEND: running, request high.
- HALT: held, counter zero, request low.

Its transitions are:
- EXPIRE: COUNT to PEND, on a counter wrap.
- REARM: PEND to PEND, on a wrap while the request is already high.
- CLEAR: any state to HALT, on a write with bit 4 set.
- RELEASE: HALT to COUNT, on a write with bit 4 clear.

Reset enters COUNT.

Top module: `cart_ivl_timer`

## Requirements
- R1: Reset clears the stored control word, the counter and the interrupt request, and enters COUNT. prg_bank_lo reads 0 and prg_bank_hi reads 1 after reset.
- R2: While stored bit 4 is 0, the counter advances by one per clock. The request rises on the edge that completes exactly T counting cycles, where T = 2^BASE_BIT + dip_sw × 2^SW_LSB.
- R3: On expiry the counter returns to 0 and keeps counting. The request stays high through further expiries.
- R4: A write with ctl_val bit 4 set clears the counter and drops the request at the next edge. While stored bit 4 stays 1 the counter holds at 0 and no request is raised.
- R5: A write with bit 4 clear made from HALT starts counting on the edge after the write edge. The same write made while running leaves the count and the request undisturbed.
- R6: If the switches change so that the threshold falls to or below the current count, the next counting edge expires.
- R7: With stored bit 3 = 0, prg_bank_lo = 2 × ctl[2:1] and prg_bank_hi = 2 × ctl[2:1] + 1. These are 16 KB bank numbers.
- R8: With stored bit 3 = 1, prg_bank_lo = 8 | (mmc_bank_lo & 7) and prg_bank_hi = 8 | (mmc_bank_hi & 7).
- R9: With ctl_wr low, ctl_val is ignored and the stored control word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_val | input | 5 | Control word value |
| dip_sw | input | SW_W | Switch setting for the period |
| mmc_bank_lo | input | PB_W | Mapper's 16 KB bank for the low window |
| mmc_bank_hi | input | PB_W | Mapper's 16 KB bank for the high window |
| irq | output | 1 | Level-sensitive interrupt request |
| prg_bank_lo | output | PB_W | Overriding 16 KB bank, low window |
| prg_bank_hi | output | PB_W | Overriding 16 KB bank, high window |

## Verification
The bench measures the exact cycle count from release to the request for the lowest, default and highest switch settings. An off-by-one in the compare or in the start cycle would shift that count by one. It lowers the switches mid-count below the current count: an equality-only compare would then run on to counter wrap and never fire. It writes bit-4-clear words into a pending request, which a design that clears on any write would drop. It also sweeps every control value through both PRG layouts, where a swapped bit or a missing bank-8 offset shows directly on the bank outputs.

// File: rtl/cart_ivl_pkg.sv
package cart_ivl_pkg;
    localparam int CTL_W    = 5;
    localparam int HALT_BIT = 4;
    localparam int MODE_BIT = 3;

    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_PEND  = 2'd1,
        ST_HALT  = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/ivt_ctl_reg.sv
module ivt_ctl_reg
    import cart_ivl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] val,
    output logic [CTL_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr)
            q <= val;
    end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int CNT_W = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] thr,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W:0] nxt;

    assign nxt  = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign wrap = en && !clr && (nxt >= {1'b0, thr});

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en)
            cnt <= wrap ? '0 : nxt[CNT_W-1:0];
    end
endmodule

// File: rtl/ivt_fsm.sv
module ivt_fsm
    import cart_ivl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_req,
    input  logic       rel_req,
    input  logic       wrap,
    output tmr_state_e state,
    output logic       irq,
    output logic       cnt_en
);
    tmr_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COUNT: begin
                if (clr_req)   state_nx = ST_HALT;   // CLEAR
                else if (wrap) state_nx = ST_PEND;   // EXPIRE
            end
            ST_PEND: begin
                if (clr_req)   state_nx = ST_HALT;   // CLEAR
                else           state_nx = ST_PEND;   // REARM on wrap
            end
            ST_HALT: begin
                if (clr_req)      state_nx = ST_HALT;
                else if (rel_req) state_nx = ST_COUNT; // RELEASE
            end
            default: state_nx = ST_COUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_COUNT;
        else     state <= state_nx;
    end

    always_comb begin
        irq    = 1'b0;
        cnt_en = 1'b0;
        unique case (state)
            ST_COUNT: cnt_en = 1'b1;
            ST_PEND:  begin cnt_en = 1'b1; irq = 1'b1; end
            ST_HALT:  cnt_en = 1'b0;
            default:  cnt_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/ivt_prg_map.sv
module ivt_prg_map #(
    parameter int PB_W = 4
) (
    input  logic            mode16,
    input  logic [1:0]      sel32,
    input  logic [PB_W-1:0] mmc_lo,
    input  logic [PB_W-1:0] mmc_hi,
    output logic [PB_W-1:0] bank_lo,
    output logic [PB_W-1:0] bank_hi
);
    localparam int NWIN = 2;

    logic [PB_W-1:0] src [NWIN];
    logic [PB_W-1:0] dst [NWIN];

    assign src[0]  = mmc_lo;
    assign src[1]  = mmc_hi;
    assign bank_lo = dst[0];
    assign bank_hi = dst[1];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        always_comb begin
            if (mode16)
                dst[w] = PB_W'({1'b1, src[w][2:0]});
            else
                dst[w] = PB_W'({sel32, w[0]});
        end
    end
endmodule

// File: rtl/cart_ivl_timer.sv
module cart_ivl_timer
    import cart_ivl_pkg::*;
#(
    parameter int CNT_W    = 30,
    parameter int BASE_BIT = 29,
    parameter int SW_LSB   = 25,
    parameter int SW_W     = 4,
    parameter int PB_W     = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ctl_wr,
    input  logic [4:0]      ctl_val,
    input  logic [SW_W-1:0] dip_sw,
    input  logic [PB_W-1:0] mmc_bank_lo,
    input  logic [PB_W-1:0] mmc_bank_hi,
    output logic            irq,
    output logic [PB_W-1:0] prg_bank_lo,
    output logic [PB_W-1:0] prg_bank_hi
);
    logic [CTL_W-1:0] ctl_q;
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic             cnt_en;
    logic             clr_req;
    logic             rel_req;
    tmr_state_e       state;

    assign thr     = (CNT_W'(1) << BASE_BIT) | (CNT_W'(dip_sw) << SW_LSB);
    assign clr_req = ctl_wr &&  ctl_val[HALT_BIT];
    assign rel_req = ctl_wr && !ctl_val[HALT_BIT];

    ivt_ctl_reg u_ctl (
        .clk (clk),
        .rst (rst),
        .wr  (ctl_wr),
        .val (ctl_val),
        .q   (ctl_q)
    );

    ivt_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .clr_req (clr_req),
        .rel_req (rel_req),
        .wrap    (wrap),
        .state   (state),
        .irq     (irq),
        .cnt_en  (cnt_en)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_req),
        .en   (cnt_en),
        .thr  (thr),
        .wrap (wrap),
        .cnt  (cnt)
    );

    ivt_prg_map #(.PB_W(PB_W)) u_map (
        .mode16  (ctl_q[MODE_BIT]),
        .sel32   (ctl_q[2:1]),
        .mmc_lo  (mmc_bank_lo),
        .mmc_hi  (mmc_bank_hi),
        .bank_lo (prg_bank_lo),
        .bank_hi (prg_bank_hi)
    );
endmodule

// File: rtl/cart_ivl_timer_chk.sv
module cart_ivl_timer_chk #(
    parameter int CNT_W = 30,
    parameter int PB_W  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_wr,
    input logic [4:0]       ctl_val,
    input logic [4:0]       ctl_q,
    input logic [CNT_W-1:0] cnt,
    input logic             irq,
    input logic [PB_W-1:0]  mmc_bank_lo,
    input logic [PB_W-1:0]  prg_bank_lo,
    input logic [PB_W-1:0]  prg_bank_hi
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!irq && cnt == '0 && ctl_q == '0));

    a_r4_clear_write: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_val[4]) |=> (!irq && cnt == '0));

    a_r4_hold_zero: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[4] && !ctl_wr) |=> (cnt == '0 && !irq));

    a_r3_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !(ctl_wr && ctl_val[4])) |=> irq);

    a_r3_rise_wraps: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (cnt == '0));

    a_r9_ctl_stable: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> $stable(ctl_q));

    a_r7_pair32: assert property (@(posedge clk) disable iff (rst)
        !ctl_q[3] |-> (prg_bank_hi == prg_bank_lo + PB_W'(1) && !prg_bank_lo[0]));

    a_r8_upper16: assert property (@(posedge clk) disable iff (rst)
        ctl_q[3] |-> (prg_bank_lo[3] && prg_bank_hi[3]
                      && prg_bank_lo[2:0] == mmc_bank_lo[2:0]));
endmodule

bind cart_ivl_timer cart_ivl_timer_chk #(.CNT_W(CNT_W), .PB_W(PB_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr      (ctl_wr),
    .ctl_val     (ctl_val),
    .ctl_q       (ctl_q),
    .cnt         (cnt),
    .irq         (irq),
    .mmc_bank_lo (mmc_bank_lo),
    .prg_bank_lo (prg_bank_lo),
    .prg_bank_hi (prg_bank_hi)
);

// File: tb/sim_cart_ivl_timer.sv
`timescale 1ns/1ps
module sim_cart_ivl_timer;
    localparam int CNT_W    = 10;
    localparam int BASE_BIT = 9;
    localparam int SW_LSB   = 5;
    localparam int SW_W     = 4;
    localparam int PB_W     = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ctl_wr = 1'b0;
    logic [4:0]      ctl_val = '0;
    logic [SW_W-1:0] dip_sw = 4'd4;
    logic [PB_W-1:0] mmc_bank_lo = '0;
    logic [PB_W-1:0] mmc_bank_hi = '0;
    logic            irq;
    logic [PB_W-1:0] prg_bank_lo;
    logic [PB_W-1:0] prg_bank_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state kept from the requirements
    int   m_cnt = 0;
    logic [4:0] m_ctl = '0;
    bit   m_irq = 0;

    always #10 clk = ~clk;

    cart_ivl_timer #(
        .CNT_W(CNT_W), .BASE_BIT(BASE_BIT), .SW_LSB(SW_LSB),
        .SW_W(SW_W), .PB_W(PB_W)
    ) u0 (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_val(ctl_val),
        .dip_sw(dip_sw), .mmc_bank_lo(mmc_bank_lo), .mmc_bank_hi(mmc_bank_hi),
        .irq(irq), .prg_bank_lo(prg_bank_lo), .prg_bank_hi(prg_bank_hi)
    );

    function automatic int period(input int sw);
        return (1 << BASE_BIT) + sw * (1 << SW_LSB);
    endfunction

    function automatic int exp_lo(input logic [4:0] c, input int m);
        return c[3] ? (8 | (m & 7)) : 2 * int'(c[2:1]);
    endfunction

    function automatic int exp_hi(input logic [4:0] c, input int m);
        return c[3] ? (8 | (m & 7)) : 2 * int'(c[2:1]) + 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: reference steps at the edge, outputs compared at the falling edge
    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_cnt = 0; m_ctl = '0; m_irq = 0;
        end else begin
            bit run;
            run = !m_ctl[4];
            if (ctl_wr && ctl_val[4]) begin
                m_cnt = 0; m_irq = 0;
            end else if (run) begin
                if (m_cnt + 1 >= period(int'(dip_sw))) begin
                    m_cnt = 0; m_irq = 1;
                end else m_cnt = m_cnt + 1;
            end
            if (ctl_wr) m_ctl = ctl_val;
        end
        @(negedge clk);
        chk("R2/R3/R4 irq", int'(irq), int'(m_irq));
        chk("R7/R8 lo", int'(prg_bank_lo), exp_lo(m_ctl, int'(mmc_bank_lo)));
        chk("R7/R8 hi", int'(prg_bank_hi), exp_hi(m_ctl, int'(mmc_bank_hi)));
        ctl_wr = 1'b0;
    endtask

    task automatic wr(input logic [4:0] v);
        ctl_wr = 1'b1; ctl_val = v;
        tick();
    endtask

    // release from halt, then count edges until the request rises
    task automatic measure(input int sw, input string req);
        int k;
        dip_sw = SW_W'(sw);
        wr(5'h10);
        wr(5'h00);
        k = 0;
        while (!irq && k < 2000) begin
            tick();
            k++;
        end
        chk(req, k, period(sw));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        // R1: reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 lo", int'(prg_bank_lo), 0);
        chk("R1 hi", int'(prg_bank_hi), 1);

        // R2: exact period for default, lowest and highest switch settings
        measure(4, "R2 period sw=4");
        // R3: request stays high across another full period
        repeat (period(4) + 5) tick();
        chk("R3 sticky", int'(irq), 1);
        // R5: bit-4-clear write while pending keeps the request
        wr(5'h06);
        chk("R5 keep irq", int'(irq), 1);
        // R4: clear and hold
        wr(5'h1F);
        chk("R4 cleared", int'(irq), 0);
        repeat (1500) tick();
        chk("R4 held", int'(irq), 0);
        measure(0, "R2 period sw=0");
        measure(15, "R2 period sw=15");

        // R6: lower the threshold below the current count
        dip_sw = 4'd15;
        wr(5'h10);
        wr(5'h00);
        repeat (900) tick();
        chk("R6 not yet", int'(irq), 0);
        dip_sw = 4'd0;
        tick();
        chk("R6 immediate expiry", int'(irq), 1);

        // R7/R8: every control value in both layouts
        for (int v = 0; v < 32; v++) begin
            mmc_bank_lo = PB_W'($urandom);
            mmc_bank_hi = PB_W'($urandom);
            wr(5'(v));
            chk("R7/R8 sweep lo", int'(prg_bank_lo), exp_lo(5'(v), int'(mmc_bank_lo)));
        end

        // R9: value changes with the strobe low are ignored
        wr(5'h0A);
        ctl_val = 5'h15;
        tick();
        chk("R9 ignored lo", int'(prg_bank_lo), 8 | (int'(mmc_bank_lo) & 7));

        // random mix
        for (int i = 0; i < 30000; i++) begin
            if ($urandom_range(0, 99) == 0) begin
                ctl_wr = 1'b1;
                ctl_val = 5'($urandom);
                if ($urandom_range(0, 3) != 0) ctl_val[4] = 1'b0;
            end
            if ($urandom_range(0, 999) == 0) dip_sw = SW_W'($urandom);
            if ($urandom_range(0, 49) == 0) begin
                mmc_bank_lo = PB_W'($urandom);
                mmc_bank_hi = PB_W'($urandom);
            end
            if ($urandom_range(0, 9999) == 0) rst = 1'b1;
            tick();
            rst = 1'b0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule